// File: doc/BRIEF.md
# Sampled-Data Tone-Tracking PLL

This block locks a numerically controlled oscillator onto one sinusoidal tone carried by a stream of signed samples. Each time the sample strobe is high, it multiplies the incoming sample by the oscillator's own sine output. The product is rounded, not truncated, and becomes the phase error. A proportional-plus-integral loop filter turns that error into a frequency offset, and the offset is added to a nominal frequency word to steer a 16-bit phase accumulator.

Start-up is fast and an absent tone does not run the loop away, for three reasons. The integrator starts at the nominal tone frequency (zero offset). It is confined to a programmable symmetric window, and whenever an update would leave that window it is reloaded with the upper limit. The loop gains are two right-shift amounts, taken from a wide acquisition pair or a narrow tracking pair depending on an external lock input. The sine output uses a folded quarter-wave table, computed at elaboration as a parabolic approximation of a half cycle.

Top module: `dpll_track`

## Requirements
- R1: While rst_ni is low, phase_o is 0 and freq_o equals nom_freq_i, because the integrator and the frequency offset are both zero.
- R2: On every clock edge with en_i high, phase_o advances by the freq_o value present before that edge, modulo 2^16.
- R3: sine_o is taken from phase_o[15:8]. Bit 7 is the half-cycle sign and gives a negative value when set. Bit 6 selects a mirrored index (63 - bits[5:0]) when set, and bits[5:0] give the index otherwise. The magnitude is floor(2047*(2k+1)*(255-2k)/16384) for index k.
- R4: The phase error is (sample_i*sine_o + 1024) arithmetically shifted right by 11. A sample of -1 against a sine of +31 gives an error of 0, so the frequency does not drift.
- R5: On each strobe, the integrator adds the error shifted right arithmetically by the integral shift. If the sum is above +win_i or below -win_i, the integrator is loaded with +win_i instead.
- R6: On each strobe, the offset becomes the new integrator value plus the error shifted right by the proportional shift, saturated to the range ±win_i. freq_o equals nom_freq_i plus the offset, modulo 2^16.
- R7: With lock_i low, the shifts come from acq_kp_sh_i and acq_ki_sh_i. With lock_i high, they come from trk_kp_sh_i and trk_ki_sh_i.
- R8: With en_i low, phase_o, the integrator and freq_o are held, whatever sample_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Sample strobe; all state updates only when high |
| sample_i | input | 12 | Signed input sample |
| nom_freq_i | input | 16 | Nominal frequency word (phase step per sample) |
| win_i | input | 15 | Half-width of the frequency window |
| lock_i | input | 1 | Selects the tracking gain pair when high |
| acq_kp_sh_i | input | 4 | Proportional shift in acquisition |
| acq_ki_sh_i | input | 4 | Integral shift in acquisition |
| trk_kp_sh_i | input | 4 | Proportional shift in tracking |
| trk_ki_sh_i | input | 4 | Integral shift in tracking |
| phase_o | output | 16 | NCO phase accumulator |
| sine_o | output | 12 | Signed NCO sine sample |
| freq_o | output | 16 | Current frequency word |

## Verification
The bench steps the phase through all 256 table positions and compares each sine value with the arithmetic formula. A fold or sign slip would show up as a mirrored or inverted quadrant. It holds a -1 input against a small positive sine with zero shifts: a truncating detector would walk freq_o down by one on every strobe, while a rounding one keeps it fixed. It then runs long pseudo-random sample sequences against a narrow window and switches the lock input part-way through. A design that clamps instead of reloading to the upper limit, that misses the output saturation, or that swaps the gain pairs would leave the bench's cycle-accurate model within a few strobes. Strobe-low stretches with large samples confirm that nothing moves without en_i.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  localparam int SH_W = 4;

  typedef struct packed {
    logic [SH_W-1:0] kp_sh;
    logic [SH_W-1:0] ki_sh;
  } gain_sh_t;
endpackage

// File: rtl/dpll_sine_lut.sv
module dpll_sine_lut #(
  parameter int LUT_AW = 6,
  parameter int SINE_W = 12
) (
  input  logic [LUT_AW+1:0]        phase_top_i,
  output logic signed [SINE_W-1:0] sine_o
);
  localparam int QN  = 1 << LUT_AW;
  localparam int AMP = (1 << (SINE_W - 1)) - 1;

  logic [SINE_W-1:0] rom [QN];

  // parabolic half-cycle sampled at quarter-cell centres
  for (genvar k = 0; k < QN; k++) begin : g_rom
    localparam longint VAL =
      (longint'(AMP) * (2 * k + 1) * (4 * QN - 2 * k - 1)) / (4 * QN * QN);
    assign rom[k] = SINE_W'(VAL);
  end

  logic              neg_half;
  logic              mirror;
  logic [LUT_AW-1:0] low;
  logic [LUT_AW-1:0] idx;
  logic [SINE_W-1:0] mag;

  assign neg_half = phase_top_i[LUT_AW+1];
  assign mirror   = phase_top_i[LUT_AW];
  assign low      = phase_top_i[LUT_AW-1:0];
  assign idx      = mirror ? ~low : low;
  assign mag      = rom[idx];
  assign sine_o   = neg_half ? -$signed(mag) : $signed(mag);
endmodule

// File: rtl/dpll_phase_det.sv
module dpll_phase_det #(
  parameter int SAMPLE_W = 12,
  parameter int SINE_W   = 12,
  parameter int ERR_W    = 13
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [SINE_W-1:0]   sine_i,
  output logic signed [ERR_W-1:0]    err_o
);
  localparam int PW = SAMPLE_W + SINE_W;
  localparam logic signed [PW-1:0] HALF = PW'(2 ** (SINE_W - 2));

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] biased;

  assign prod = $signed({{SINE_W{sample_i[SAMPLE_W-1]}}, sample_i}) *
                $signed({{SAMPLE_W{sine_i[SINE_W-1]}}, sine_i});
  // round to nearest: truncation would bias the loop toward one direction
  assign biased = prod + HALF;
  assign err_o  = ERR_W'(biased >>> (SINE_W - 1));
endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter #(
  parameter int ERR_W = 13,
  parameter int WIN_W = 15,
  parameter int OFF_W = 17,
  parameter int SH_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic [WIN_W-1:0]        win_i,
  input  logic [SH_W-1:0]         kp_sh_i,
  input  logic [SH_W-1:0]         ki_sh_i,
  output logic signed [OFF_W-1:0] off_o
);
  localparam int ACC_W = OFF_W + 1;

  logic signed [OFF_W-1:0] integ_q, integ_d;
  logic signed [OFF_W-1:0] off_q, off_d;
  logic signed [ACC_W-1:0] err_x, ki_term, kp_term;
  logic signed [ACC_W-1:0] win_p, win_n, integ_sum, out_sum;

  assign err_x     = ACC_W'(err_i);
  assign ki_term   = err_x >>> ki_sh_i;
  assign kp_term   = err_x >>> kp_sh_i;
  assign win_p     = ACC_W'({1'b0, win_i});
  assign win_n     = -win_p;
  assign integ_sum = ACC_W'(integ_q) + ki_term;

  always_comb begin
    // leaving the window on either side reloads the upper limit
    if (integ_sum > win_p || integ_sum < win_n) integ_d = OFF_W'(win_p);
    else                                        integ_d = OFF_W'(integ_sum);
    out_sum = ACC_W'(integ_d) + kp_term;
    if (out_sum > win_p)      off_d = OFF_W'(win_p);
    else if (out_sum < win_n) off_d = OFF_W'(win_n);
    else                      off_d = OFF_W'(out_sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= '0;
      off_q   <= '0;
    end else if (en_i) begin
      integ_q <= integ_d;
      off_q   <= off_d;
    end
  end

  assign off_o = off_q;

  p_integ_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (integ_q <= $past(win_p)) && (integ_q >= $past(win_n)));

  p_off_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (off_q <= $past(win_p)) && (off_q >= $past(win_n)));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(integ_q) && $stable(off_q));
endmodule

// File: rtl/dpll_nco.sv
module dpll_nco #(
  parameter int PHASE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] freq_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_q <= '0;
    else if (en_i) phase_q <= phase_q + freq_i;
  end

  assign phase_o = phase_q;

  p_nco_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_q));
endmodule

// File: rtl/dpll_track.sv
module dpll_track
  import dpll_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int PHASE_W  = 16,
  parameter int SINE_W   = 12,
  parameter int LUT_AW   = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [PHASE_W-1:0]         nom_freq_i,
  input  logic [PHASE_W-2:0]         win_i,
  input  logic                       lock_i,
  input  logic [SH_W-1:0]            acq_kp_sh_i,
  input  logic [SH_W-1:0]            acq_ki_sh_i,
  input  logic [SH_W-1:0]            trk_kp_sh_i,
  input  logic [SH_W-1:0]            trk_ki_sh_i,
  output logic [PHASE_W-1:0]         phase_o,
  output logic signed [SINE_W-1:0]   sine_o,
  output logic [PHASE_W-1:0]         freq_o
);
  localparam int ERR_W = SAMPLE_W + 1;
  localparam int WIN_W = PHASE_W - 1;
  localparam int OFF_W = PHASE_W + 1;

  gain_sh_t acq_g, trk_g, sel_g;
  logic signed [ERR_W-1:0] err;
  logic signed [OFF_W-1:0] off;

  assign acq_g = '{kp_sh: acq_kp_sh_i, ki_sh: acq_ki_sh_i};
  assign trk_g = '{kp_sh: trk_kp_sh_i, ki_sh: trk_ki_sh_i};
  assign sel_g = lock_i ? trk_g : acq_g;

  dpll_sine_lut #(.LUT_AW(LUT_AW), .SINE_W(SINE_W)) i_lut (
    .phase_top_i (phase_o[PHASE_W-1 -: LUT_AW+2]),
    .sine_o      (sine_o)
  );

  dpll_phase_det #(.SAMPLE_W(SAMPLE_W), .SINE_W(SINE_W), .ERR_W(ERR_W)) i_pd (
    .sample_i (sample_i),
    .sine_i   (sine_o),
    .err_o    (err)
  );

  dpll_loop_filter #(.ERR_W(ERR_W), .WIN_W(WIN_W), .OFF_W(OFF_W), .SH_W(SH_W)) i_lf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .err_i   (err),
    .win_i   (win_i),
    .kp_sh_i (sel_g.kp_sh),
    .ki_sh_i (sel_g.ki_sh),
    .off_o   (off)
  );

  assign freq_o = nom_freq_i + PHASE_W'(off);

  dpll_nco #(.PHASE_W(PHASE_W)) i_nco (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .freq_i  (freq_o),
    .phase_o (phase_o)
  );

  p_phase_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> phase_o == $past(phase_o + freq_o));

  p_sine_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sine_o[SINE_W-1] == phase_o[PHASE_W-1]);
endmodule

// File: tb/test_dpll_track.sv
module test_dpll_track;
  localparam int CLK_PERIOD = 10;

  logic               clk_i = 1'b0;
  logic               rst_ni;
  logic               en_i;
  logic signed [11:0] sample_i;
  logic [15:0]        nom_freq_i;
  logic [14:0]        win_i;
  logic               lock_i;
  logic [3:0]         acq_kp_sh_i, acq_ki_sh_i, trk_kp_sh_i, trk_ki_sh_i;
  logic [15:0]        phase_o;
  logic signed [11:0] sine_o;
  logic [15:0]        freq_o;

  int checks = 0;
  int errors = 0;
  int m_phase, m_integ, m_off;
  logic [31:0] lfsr = 32'h1ACE_5EED;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dpll_track i_dpll_track (
    .clk_i, .rst_ni, .en_i, .sample_i, .nom_freq_i, .win_i, .lock_i,
    .acq_kp_sh_i, .acq_ki_sh_i, .trk_kp_sh_i, .trk_ki_sh_i,
    .phase_o, .sine_o, .freq_o
  );

  function automatic int f_sine(int ph);
    int top, idx, q;
    top = (ph >> 8) & 255;
    idx = top & 63;
    if ((top & 64) != 0) idx = 63 - idx;
    q = (2047 * (2 * idx + 1) * (255 - 2 * idx)) / 16384;
    return ((top & 128) != 0) ? -q : q;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs(string tag);
    check({tag, " R2 phase"}, int'(phase_o), m_phase);
    check({tag, " R6 freq"}, int'(freq_o), (int'(nom_freq_i) + m_off) & 16'hFFFF);
    check({tag, " R3 sine"}, int'(sine_o), f_sine(m_phase));
  endtask

  // called at a falling edge; updates inputs, model, then checks at next falling edge
  task automatic step(bit e, int smp, string tag);
    int s, err, kp, ki, nx, o, w;
    en_i     = e;
    sample_i = 12'(smp);
    if (e) begin
      w   = int'(win_i);
      s   = f_sine(m_phase);
      err = (smp * s + 1024) >>> 11;
      kp  = lock_i ? int'(trk_kp_sh_i) : int'(acq_kp_sh_i);
      ki  = lock_i ? int'(trk_ki_sh_i) : int'(acq_ki_sh_i);
      nx  = m_integ + (err >>> ki);
      if (nx > w || nx < -w) nx = w;
      o = nx + (err >>> kp);
      if (o > w) o = w;
      else if (o < -w) o = -w;
      m_phase = (m_phase + int'(nom_freq_i) + m_off) & 16'hFFFF;
      m_integ = nx;
      m_off   = o;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    check_outputs(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    en_i   = 1'b0;
    m_phase = 0; m_integ = 0; m_off = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R1 phase reset", int'(phase_o), 0);
    check("R1 freq reset", int'(freq_o), int'(nom_freq_i));
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  function automatic int next_smp();
    logic signed [11:0] t;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    t = lfsr[11:0];
    return int'(t);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; en_i = 1'b0; sample_i = '0; lock_i = 1'b0;
    nom_freq_i = 16'h1234; win_i = 15'd1000;
    acq_kp_sh_i = 4'd0; acq_ki_sh_i = 4'd0; trk_kp_sh_i = 4'd0; trk_ki_sh_i = 4'd0;
    @(negedge clk_i);
    do_reset();
    check("R3 sine at reset", int'(sine_o), f_sine(0));

    // R3/R2: sweep every table position with zero input
    do_reset();
    nom_freq_i = 16'd256;
    for (int i = 0; i < 256; i++) step(1'b1, 0, "sweep");

    // R8: strobe low with large samples
    for (int i = 0; i < 8; i++) step(1'b0, (i & 1) ? 2047 : -2048, "R8 hold");

    // R4: rounding keeps frequency fixed with tiny negative input
    nom_freq_i = 16'd0;
    do_reset();
    for (int i = 0; i < 20; i++) begin
      step(1'b1, -1, "R4 round");
      check("R4 no drift", int'(freq_o), 0);
    end
    for (int i = 0; i < 8; i++) step(1'b1, 34, "R4 round up");

    // R5/R6: narrow window, pushes both ways, reload to upper limit
    nom_freq_i = 16'h0800; win_i = 15'd50;
    acq_kp_sh_i = 4'd0; acq_ki_sh_i = 4'd0;
    do_reset();
    for (int i = 0; i < 40; i++) step(1'b1, 2047, "R5 up");
    for (int i = 0; i < 80; i++) step(1'b1, -2048, "R5 down");

    // R7: pseudo-random input, acquisition then tracking gains
    nom_freq_i = 16'h0C40; win_i = 15'd300;
    acq_kp_sh_i = 4'd1; acq_ki_sh_i = 4'd3;
    trk_kp_sh_i = 4'd4; trk_ki_sh_i = 4'd7;
    do_reset();
    for (int i = 0; i < 400; i++) step(1'b1, next_smp(), "R7 acq");
    lock_i = 1'b1;
    for (int i = 0; i < 400; i++) begin
      step((i % 5) != 4, next_smp(), "R7 trk");
    end
    lock_i = 1'b0;
    win_i = 15'd20;
    for (int i = 0; i < 200; i++) step(1'b1, next_smp(), "R5 shrink");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule